// File: doc/BRIEF.md
# GPIO Interrupt Register Bank

This block watches 31 general-purpose input pins and reports four conditions per pin: the pin being low, the pin being high, a falling transition and a rising transition. Each pin owns a 4-bit field. The fields are packed eight to a 32-bit word into three register arrays on a simple 32-bit register bus. The enable array selects which conditions may interrupt. The raw status array shows every condition, whether or not it is enabled. The masked status array shows the raw status filtered by the enables. A single interrupt output is raised while any masked bit is set.

Every pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with its value one cycle earlier. Edge bits are sticky and software clears them by writing ones. Level bits follow the pin and cannot be written.

The register port ignores the access width. A byte or halfword write is copied across the whole addressed word, and the whole word is written. Decode looks only at the word address.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin n owns bits 4*(n mod 8) to 4*(n mod 8)+3 of word n/8 in each array. Inside a field, bit 0 is low level, bit 1 is high level, bit 2 is falling edge and bit 3 is rising edge. The top nibble of word 3, which no pin uses, always reads zero.
- R2: Byte offsets 0x00/0x04/0x08/0x0C hold the enable words 0..3, 0x10..0x1C hold the raw status words and 0x20..0x2C hold the masked status words. Address bits 1:0 play no part in decode. Offsets 0x30 and above read zero, and writes to them change nothing.
- R3: Size code 2'b00 is a byte, 2'b01 is a halfword, and 2'b10 or 2'b11 is a word. A byte write takes the byte lane selected by address bits 1:0 and copies it into all four lanes. A halfword write takes the half selected by address bit 1 and copies it into both halves. The resulting 32-bit value is written in full.
- R4: An enable word reads back the last value written to it, as widened by R3. Enable words change only when they are written.
- R5: Bit 1 of a raw field equals the pin level and bit 0 equals its inverse. Both bits show a pin change after two rising clock edges. Writes to level bits have no effect.
- R6: A change in the synchronised level sets the matching edge bit, which is readable after three rising clock edges from the pin change. Edge bits stay set until they are cleared.
- R7: Writing a raw status word clears each edge bit whose written bit is 1 and leaves edge bits written with 0 unchanged.
- R8: If an edge is detected in the same cycle as a clear of that edge bit, the bit ends up set.
- R9: A masked status word reads as the raw word ANDed with the enable word. Writes to masked words have no effect.
- R10: irq_o is high exactly when some masked status bit is set.
- R11: Reset clears all enables, all edge bits and the synchroniser flops. Until the pins are sampled, every pin therefore reads as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 31 | Asynchronous pin inputs |
| bus_sel_i | input | 1 | Register access valid |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Byte address within the block |
| bus_size_i | input | 2 | Access size code (R3) |
| bus_wdata_i | input | 32 | Write data in bus lane positions |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt |

## Verification
A detected edge and a software write-one-to-clear of the same raw bit can land on one clock edge. The bench provokes this by raising a pin and then issuing an all-ones write to that pin's raw word on exactly the third rising edge after the change. It expects the pin's rising bit to survive while every other edge bit in that word is cleared. Every write in the sweep, including the narrow ones, is judged by reading all twelve words and the interrupt output against an arithmetic model.

// File: rtl/gib_pkg.sv
package gib_pkg;
    localparam int FIELD_W  = 4;
    localparam int BIT_LOW  = 0;
    localparam int BIT_HIGH = 1;
    localparam int BIT_FALL = 2;
    localparam int BIT_RISE = 3;

    localparam int ARR_EN   = 0;
    localparam int ARR_RAW  = 1;
    localparam int ARR_MASK = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/gib_lane.sv
module gib_lane
    import gib_pkg::*;
(
    input  logic [31:0] data_i,
    input  logic [1:0]  lane_i,
    input  logic [1:0]  size_i,
    output logic [31:0] wide_o
);
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        byte_v = data_i[8*lane_i +: 8];
        half_v = lane_i[1] ? data_i[31:16] : data_i[15:0];
        case (xfer_size_e'(size_i))
            SZ_BYTE: wide_o = {4{byte_v}};
            SZ_HALF: wide_o = {2{half_v}};
            default: wide_o = data_i;
        endcase
    end

    // R3
    always_comb begin
        lane_rep_chk: assert (size_i != 2'b00 ||
            (wide_o[31:24] == wide_o[7:0] && wide_o[23:16] == wide_o[7:0] &&
             wide_o[15:8] == wide_o[7:0]));
    end
endmodule

// File: rtl/gib_sync.sv
module gib_sync #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.s2;
    assign prev_o  = st_q.prev;
endmodule

// File: rtl/gib_edge.sv
module gib_edge #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] clr_rise_i,
    input  logic [W-1:0] clr_fall_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] rise;
        logic [W-1:0] fall;
    } edge_t;

    edge_t st_d, st_q;
    logic [2*W-1:0] set_v, clr_v, cur_v;

    always_comb begin
        st_d.rise = (st_q.rise & ~clr_rise_i) | (level_i & ~prev_i);
        st_d.fall = (st_q.fall & ~clr_fall_i) | (~level_i & prev_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    assign set_v = {level_i & ~prev_i, ~level_i & prev_i};
    assign clr_v = {clr_rise_i, clr_fall_i};
    assign cur_v = {rise_o, fall_o};

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((cur_v & $past(set_v)) == $past(set_v)));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v == '0) |=> ((cur_v & $past(cur_v)) == $past(cur_v)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gib_pkg::*;
#(
    parameter int NUM_PINS = 31,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [1:0]          bus_size_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_o
);
    localparam int FIELD_BITS = NUM_PINS * FIELD_W;
    localparam int WORDS      = (FIELD_BITS + 31) / 32;
    localparam int PAD_BITS   = WORDS * 32;

    typedef struct packed {
        logic [FIELD_BITS-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM_PINS-1:0] level, prev, rise, fall, clr_rise, clr_fall;
    logic [31:0]         wide;
    logic [PAD_BITS-1:0] en_pad, raw_pad, mask_pad;
    logic                wr_fire;
    int                  arr_i, slot_i;

    gib_sync #(.W(NUM_PINS)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(level), .prev_o(prev)
    );

    gib_edge #(.W(NUM_PINS)) i_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level), .prev_i(prev),
        .clr_rise_i(clr_rise), .clr_fall_i(clr_fall),
        .rise_o(rise), .fall_o(fall)
    );

    gib_lane i_lane (
        .data_i(bus_wdata_i), .lane_i(bus_addr_i[1:0]),
        .size_i(bus_size_i), .wide_o(wide)
    );

    // word decode: array index and word slot, byte bits ignored
    always_comb begin
        arr_i  = 32'(bus_addr_i[ADDR_W-1:2]) / WORDS;
        slot_i = 32'(bus_addr_i[ADDR_W-1:2]) % WORDS;
    end

    assign wr_fire = bus_sel_i && bus_wr_i;

    // field assembly per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign raw_pad[FIELD_W*p + BIT_LOW]  = ~level[p];
        assign raw_pad[FIELD_W*p + BIT_HIGH] = level[p];
        assign raw_pad[FIELD_W*p + BIT_FALL] = fall[p];
        assign raw_pad[FIELD_W*p + BIT_RISE] = rise[p];
    end
    if (PAD_BITS > FIELD_BITS) begin : g_pad
        assign raw_pad[PAD_BITS-1:FIELD_BITS] = '0;
    end

    always_comb begin
        en_pad                 = '0;
        en_pad[FIELD_BITS-1:0] = st_q.en;
    end

    assign mask_pad = raw_pad & en_pad;
    assign irq_o    = |mask_pad;

    always_comb begin
        st_d     = st_q;
        clr_rise = '0;
        clr_fall = '0;
        if (wr_fire && arr_i == ARR_EN) begin
            for (int b = 0; b < FIELD_BITS; b++) begin
                if (b / 32 == slot_i) st_d.en[b] = wide[b % 32];
            end
        end
        if (wr_fire && arr_i == ARR_RAW) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if ((FIELD_W*p + BIT_RISE) / 32 == slot_i) begin
                    clr_rise[p] = wide[(FIELD_W*p + BIT_RISE) % 32];
                    clr_fall[p] = wide[(FIELD_W*p + BIT_FALL) % 32];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            case (arr_i)
                ARR_EN:   bus_rdata_o = en_pad[slot_i*32 +: 32];
                ARR_RAW:  bus_rdata_o = raw_pad[slot_i*32 +: 32];
                ARR_MASK: bus_rdata_o = mask_pad[slot_i*32 +: 32];
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && arr_i == ARR_EN) |=> $stable(st_q.en));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|st_q.en));

    // R9
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && arr_i == ARR_MASK) |->
        ((bus_rdata_o & ~en_pad[slot_i*32 +: 32]) == 32'h0));
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] pins = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [1:0]  size = 2'b10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    logic [30:0] lvl_m = '0, rise_m = '0, fall_m = '0;
    logic [31:0] en_m [4];

    always #2 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_size_i(size), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] raw_exp(int w);
        logic [31:0] r = '0;
        for (int n = 0; n < 8; n++) begin
            int pn = 8*w + n;
            if (pn < 31) r[4*n +: 4] = {rise_m[pn], fall_m[pn], lvl_m[pn], ~lvl_m[pn]};
        end
        return r;
    endfunction

    function automatic logic [31:0] rep(logic [1:0] sz, logic [1:0] ln, logic [31:0] d);
        if (sz == 2'b00) return {4{d[8*ln +: 8]}};
        if (sz == 2'b01) return ln[1] ? {2{d[31:16]}} : {2{d[15:0]}};
        return d;
    endfunction

    task automatic cmp(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        logic        irq_e = 1'b0;
        for (int w = 0; w < 4; w++) begin
            logic [1:0] lo = 2'(w);
            rd(6'(w*4) | 6'(lo), d); cmp({tag, " R1 R4 enable"}, d, en_m[w]);
            rd(6'(16 + w*4) | 6'(lo), d); cmp({tag, " R5 R6 raw"}, d, raw_exp(w));
            rd(6'(32 + w*4) | 6'(lo), d); cmp({tag, " R9 masked"}, d, raw_exp(w) & en_m[w]);
            if ((raw_exp(w) & en_m[w]) != 0) irq_e = 1'b1;
        end
        cmp({tag, " R10 irq"}, 32'(irq), 32'(irq_e));
    endtask

    task automatic bus_wr(logic [5:0] a, logic [1:0] sz, logic [31:0] d);
        logic [31:0] v = rep(sz, a[1:0], d);
        int w = int'(a[3:2]);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; size = sz; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        if (a[5:4] == 2'd0) en_m[w] = (w == 3) ? (v & 32'h0FFF_FFFF) : v;
        if (a[5:4] == 2'd1) begin
            for (int n = 0; n < 8; n++) begin
                int pn = 8*w + n;
                if (pn < 31) begin
                    if (v[4*n+3]) rise_m[pn] = 1'b0;
                    if (v[4*n+2]) fall_m[pn] = 1'b0;
                end
            end
        end
    endtask

    task automatic set_pin(int p, logic v);
        @(negedge clk);
        if (pins[p] != v) begin
            if (v) rise_m[p] = 1'b1; else fall_m[p] = 1'b1;
        end
        pins[p] = v; lvl_m[p] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int w = 0; w < 4; w++) en_m[w] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R11 reset");

        // R4 full word writes, R1 unused top nibble
        for (int w = 0; w < 4; w++) begin
            bus_wr(6'(w*4), 2'b10, 32'hFFFF_FFFF ^ (32'h1357_9BDF * (w + 1)));
            check_all("R4 word");
        end
        bus_wr(6'h0C, 2'b10, 32'hFFFF_FFFF);
        check_all("R1 top nibble");

        // R3 byte lanes with garbage in other lanes
        for (int ln = 0; ln < 4; ln++) begin
            logic [31:0] dd = 32'hDEAD_BEEF;
            dd[8*ln +: 8] = 8'(8'h21 * (ln + 1));
            bus_wr(6'(4 + ln), 2'b00, dd);
            check_all("R3 byte");
        end
        bus_wr(6'h08, 2'b01, 32'hA5A5_3C1E);
        check_all("R3 half low");
        bus_wr(6'h0A, 2'b01, 32'h7E81_C0DE);
        check_all("R3 half high");
        bus_wr(6'h03, 2'b11, 32'h0123_4567);
        check_all("R3 word alt");

        for (int w = 0; w < 4; w++) bus_wr(6'(w*4), 2'b10, 32'hFFFF_FFFF);

        // R6 R7 R5 sweep over every pin
        for (int p = 0; p < 31; p++) begin
            set_pin(p, 1'b1);
            check_all("R6 rise");
            bus_wr(6'(16 + (p/8)*4), 2'b10, (32'h8 << (4*(p%8))) | 32'h3333_3333);
            check_all("R7 clear rise, R5 level write ignored");
            set_pin(p, 1'b0);
            check_all("R6 fall");
        end
        for (int w = 0; w < 4; w++) bus_wr(6'(16 + w*4), 2'b01, 32'h0000_CCCC);
        check_all("R7 halfword clear");

        // R5 exact level timing
        @(negedge clk);
        pins[5] = 1'b1; lvl_m[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(6'h10, d); cmp("R5 level after two edges", d, raw_exp(0));
        @(posedge clk); @(negedge clk);
        rise_m[5] = 1'b1;
        check_all("R6 edge after three edges");

        // R8 set and clear on the same edge
        set_pin(12, 1'b1);
        set_pin(12, 1'b0);
        @(negedge clk);
        pins[9] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 6'h14; size = 2'b10; wdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        for (int p = 8; p < 16; p++) begin rise_m[p] = 1'b0; fall_m[p] = 1'b0; end
        rise_m[9] = 1'b1; lvl_m[9] = 1'b1;
        check_all("R8 set wins");

        // R9 masked writes, R2 unmapped space
        for (int w = 0; w < 4; w++) bus_wr(6'(32 + w*4), 2'b10, 32'hFFFF_FFFF);
        check_all("R9 masked write ignored");
        bus_wr(6'h30, 2'b10, 32'hFFFF_FFFF);
        bus_wr(6'h3D, 2'b00, 32'h0000_FF00);
        check_all("R2 unmapped write ignored");
        rd(6'h34, d); cmp("R2 unmapped read", d, 32'h0);

        // R10 interrupt gating
        for (int w = 0; w < 4; w++) bus_wr(6'(w*4), 2'b10, 32'h0);
        check_all("R10 all disabled");
        bus_wr(6'h0C, 2'b10, 32'h0800_0000);
        check_all("R10 pin 30 rise enabled, idle");
        set_pin(30, 1'b1);
        check_all("R10 pin 30 rise fires");
        bus_wr(6'h1C, 2'b00, 32'h0000_0088);
        check_all("R10 cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule